// File: doc/BRIEF.md
# Multichannel ADC Scan Controller

This block is the digital sequencer placed in front of an eight-input successive-approximation converter. It keeps a 32-bit control word, which is loaded through a single write port. From that word it derives a conversion clock, picks the analog channel, and decides when a conversion begins. The analog comparator and the bit-decision logic are not part of this block. Their timing is modelled by counting conversion clocks, and the block signals completion with a one-cycle done pulse.

There are two ways to start conversions. In single mode, a conversion starts either when software writes a start-now code or when a chosen edge arrives on one of six trigger inputs. A single-mode conversion always takes the full 11 conversion clocks. In burst mode, conversions repeat without further commands. The block walks the channels selected by a mask, from the lowest set bit upward, and wraps back to the lowest. Each burst conversion takes a length set by a 3-bit code. Clearing burst lets the conversion in progress finish and then stops.

Top module: `adc_scan_top`

## Requirements
- R1: After reset the control word is zero and every output (busy, convStrobe, donePulse, chanIdx, resultBits) is zero. No conversion starts until the word is written.
- R2: A conversion uses N conversion clocks. Each conversion clock lasts D+1 bus cycles, where D is the divider field in bits 15:8. busy stays high for exactly N*(D+1) cycles after the start edge, and then donePulse is high for one cycle.
- R3: A single-mode conversion always uses N=11 and reports resultBits=10, whatever the length code in bits 19:17.
- R4: In burst mode (bit 16 = 1), conversions start on the set bits of the mask in bits 7:0, in ascending order, beginning with the lowest set bit. After the highest set bit the scan wraps to the lowest.
- R5: A mask of all zeros acts as if only channel 0 were selected, in both modes.
- R6: If burst is cleared while a conversion runs, that conversion completes and no further conversion starts.
- R7: With burst set, a nonzero start field (bits 26:24) prevents any conversion from starting.
- R8: With burst clear, writing start field 1 launches exactly one conversion on the lowest set mask bit. It begins on the cycle after the write if the block is idle.
- R9: With burst clear and start field S in 2..7, trigger input S-2 starts a conversion. Bit 27 selects the edge: 0 for rising, 1 for falling. The trigger passes through a two-flop synchronizer, so its effect appears three edges after the input changes. The other trigger inputs and the opposite edge have no effect.
- R10: Trigger edges and start-now writes that arrive while a conversion is busy are ignored.
- R11: In burst mode, length code C (0..7) gives N=11-C conversion clocks and resultBits=10-C.
- R12: convStrobe is high for one cycle, the first busy cycle, of each conversion. chanIdx holds the converted channel from that cycle through the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Load the control word from wrData |
| wrData | input | 32 | Control word write value |
| trigIn | input | 6 | External trigger inputs, asynchronous |
| busy | output | 1 | Conversion in progress |
| convStrobe | output | 1 | One-cycle pulse at conversion start |
| donePulse | output | 1 | One-cycle pulse after conversion completes |
| chanIdx | output | 3 | Channel being converted |
| resultBits | output | 4 | Result width of the current conversion |

## Verification
The bench builds the block with its package defaults: eight channels, six triggers, an 8-bit divider and an 11-clock full conversion. It then varies the divider field between 0 and 1 at run time, which keeps each conversion between 4 and 22 cycles. The short conversions bring several wraps of a three-channel scan, graceful stops and trigger edges landing mid-conversion within a few hundred cycles. A behavioural model compares all five outputs on every clock.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CH_NUM    = 8;
  localparam int CH_W      = $clog2(CH_NUM);
  localparam int DIV_W     = 8;
  localparam int LEN_W     = 3;
  localparam int START_W   = 3;
  localparam int TRIG_NUM  = 6;
  localparam int FULL_CLKS = 11;
  localparam int FULL_BITS = 10;
  localparam int CNT_W     = $clog2(FULL_CLKS + 1);
  localparam int BITS_W    = $clog2(FULL_BITS + 1);
  // control word field positions
  localparam int MASK_LSB  = 0;
  localparam int DIV_LSB   = 8;
  localparam int BURST_BIT = 16;
  localparam int LEN_LSB   = 17;
  localparam int START_LSB = 24;
  localparam int EDGE_BIT  = 27;

  typedef struct packed {
    logic             startConv;
    logic [CH_W-1:0]  chan;
    logic [LEN_W-1:0] lenCode;
    logic [DIV_W-1:0] divVal;
  } convCmd_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [31:0]         wrData,
  input  logic [TRIG_NUM-1:0] trigIn,
  input  logic                busy,
  output convCmd_t            cmd
);
  logic [CH_NUM-1:0]  maskF;
  logic [DIV_W-1:0]   divF;
  logic               burstF;
  logic [LEN_W-1:0]   lenF;
  logic [START_W-1:0] startF;
  logic               edgeF;
  logic               swNow;
  logic               unusedBits;

  assign unusedBits = ^{wrData[23:20], wrData[31:28]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskF  <= '0;
      divF   <= '0;
      burstF <= 1'b0;
      lenF   <= '0;
      startF <= '0;
      edgeF  <= 1'b0;
      swNow  <= 1'b0;
    end else begin
      swNow <= wrEn && (wrData[START_LSB +: START_W] == START_W'(1)) && !wrData[BURST_BIT];
      if (wrEn) begin
        maskF  <= wrData[MASK_LSB +: CH_NUM];
        divF   <= wrData[DIV_LSB +: DIV_W];
        burstF <= wrData[BURST_BIT];
        lenF   <= wrData[LEN_LSB +: LEN_W];
        startF <= wrData[START_LSB +: START_W];
        edgeF  <= wrData[EDGE_BIT];
      end
    end
  end

  // trigger synchronizers and edge history
  logic [TRIG_NUM-1:0] syncA, syncB, prevB;
  for (genvar g = 0; g < TRIG_NUM; g++) begin : gTrig
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
        prevB[g] <= 1'b0;
      end else begin
        syncA[g] <= trigIn[g];
        syncB[g] <= syncA[g];
        prevB[g] <= syncB[g];
      end
    end
  end

  logic [START_W-1:0] trigIdx;
  logic               edgeHit;
  always_comb begin
    trigIdx = startF - START_W'(2);
    edgeHit = 1'b0;
    if (startF >= START_W'(2) && int'(trigIdx) < TRIG_NUM) begin
      edgeHit = edgeF ? (prevB[trigIdx] && !syncB[trigIdx])
                      : (syncB[trigIdx] && !prevB[trigIdx]);
    end
  end

  // channel selection
  logic            scanActive;
  logic [CH_W-1:0] lastChan;
  logic [CH_W-1:0] firstSet, nextSet, scanPick;
  logic            foundFirst, foundNext;
  always_comb begin
    firstSet   = '0;
    nextSet    = '0;
    foundFirst = 1'b0;
    foundNext  = 1'b0;
    for (int i = 0; i < CH_NUM; i++) begin
      if (maskF[i] && !foundFirst) begin
        firstSet   = CH_W'(i);
        foundFirst = 1'b1;
      end
      if (maskF[i] && scanActive && !foundNext && i > int'(lastChan)) begin
        nextSet   = CH_W'(i);
        foundNext = 1'b1;
      end
    end
    scanPick = foundNext ? nextSet : firstSet;
  end

  always_comb begin
    cmd           = '0;
    cmd.divVal    = divF;
    cmd.lenCode   = burstF ? lenF : '0;
    if (!busy) begin
      if (burstF) begin
        cmd.startConv = (startF == '0);
        cmd.chan      = scanPick;
      end else begin
        cmd.startConv = (swNow && startF == START_W'(1)) || edgeHit;
        cmd.chan      = firstSet;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanActive <= 1'b0;
      lastChan   <= '0;
    end else if (!burstF) begin
      scanActive <= 1'b0;
    end else if (cmd.startConv) begin
      scanActive <= 1'b1;
      lastChan   <= cmd.chan;
    end
  end

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.startConv |-> !busy);
  // R4
  scan_in_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.startConv && burstF && maskF != '0) |-> maskF[cmd.chan]);
  // R8
  sw_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.startConv && !burstF && startF == START_W'(1)) |-> $past(wrEn));
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  convCmd_t          cmd,
  output logic              busy,
  output logic              convStrobe,
  output logic              donePulse,
  output logic [CH_W-1:0]   chanIdx,
  output logic [BITS_W-1:0] resultBits
);
  logic [DIV_W-1:0] divLat, divCnt;
  logic [CNT_W-1:0] clkLast, clkCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      convStrobe <= 1'b0;
      donePulse  <= 1'b0;
      chanIdx    <= '0;
      resultBits <= '0;
      divLat     <= '0;
      divCnt     <= '0;
      clkLast    <= '0;
      clkCnt     <= '0;
    end else begin
      convStrobe <= 1'b0;
      donePulse  <= 1'b0;
      if (busy) begin
        if (divCnt == divLat) begin
          divCnt <= '0;
          if (clkCnt == clkLast) begin
            busy      <= 1'b0;
            donePulse <= 1'b1;
          end else begin
            clkCnt <= clkCnt + CNT_W'(1);
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
      if (cmd.startConv) begin
        busy       <= 1'b1;
        convStrobe <= 1'b1;
        divCnt     <= '0;
        clkCnt     <= '0;
        divLat     <= cmd.divVal;
        clkLast    <= CNT_W'(FULL_CLKS - 1) - CNT_W'(cmd.lenCode);
        chanIdx    <= cmd.chan;
        resultBits <= BITS_W'(FULL_BITS) - BITS_W'(cmd.lenCode);
      end
    end
  end

  // R12
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStrobe |-> busy);
  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && $past(busy)));
  // R12
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !convStrobe) |-> $stable(chanIdx));
endmodule

// File: rtl/adc_scan_top.sv
module adc_scan_top
  import adc_scan_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [31:0]         wrData,
  input  logic [TRIG_NUM-1:0] trigIn,
  output logic                busy,
  output logic                convStrobe,
  output logic                donePulse,
  output logic [CH_W-1:0]     chanIdx,
  output logic [BITS_W-1:0]   resultBits
);
  convCmd_t cmd;

  adc_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .trigIn(trigIn), .busy(busy), .cmd(cmd)
  );

  adc_scan_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busy(busy),
    .convStrobe(convStrobe), .donePulse(donePulse),
    .chanIdx(chanIdx), .resultBits(resultBits)
  );
endmodule

// File: tb/adc_scan_top_tb.sv
`timescale 1ns/1ps
module adc_scan_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [5:0] trigIn = '0;
  logic busy, convStrobe, donePulse;
  logic [2:0] chanIdx;
  logic [3:0] resultBits;

  int total = 0, bad = 0, cycles = 0;
  int strobeCnt = 0, doneCnt = 0, busyCnt = 0;
  int doneChans[$];

  always #4 clk = ~clk;

  adc_scan_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .trigIn(trigIn),
    .busy(busy), .convStrobe(convStrobe), .donePulse(donePulse),
    .chanIdx(chanIdx), .resultBits(resultBits)
  );

  // behavioural reference model
  int mMask, mDiv, mBurst, mLen, mStart, mEdge;
  bit mSw, mBusy, mStrobe, mDone, mActive;
  int mRemain, mChan, mBits, mLast;
  bit s1[6], s2[6], pv[6];

  function automatic int lowestSet(int m);
    for (int c = 0; c < 8; c++) if (m[c]) return c;
    return 0;
  endfunction

  function automatic int scanNext();
    if (mMask == 0) return 0;
    if (mActive)
      for (int j = 1; j <= 8; j++) if (mMask[(mLast + j) % 8]) return (mLast + j) % 8;
    return lowestSet(mMask);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 0; mDiv = 0; mBurst = 0; mLen = 0; mStart = 0; mEdge = 0;
      mSw = 0; mBusy = 0; mStrobe = 0; mDone = 0; mActive = 0;
      mRemain = 0; mChan = 0; mBits = 0; mLast = 0;
      for (int k = 0; k < 6; k++) begin s1[k] = 0; s2[k] = 0; pv[k] = 0; end
    end else begin
      bit go; int ch; int n;
      go = 0; ch = 0; n = 11;
      if (!mBusy) begin
        if (mBurst && mStart == 0) begin go = 1; ch = scanNext(); n = 11 - mLen; end
        else if (!mBurst && mSw && mStart == 1) begin go = 1; ch = lowestSet(mMask); end
        else if (!mBurst && mStart >= 2) begin
          int t; t = mStart - 2;
          if (mEdge ? (pv[t] && !s2[t]) : (s2[t] && !pv[t])) begin go = 1; ch = lowestSet(mMask); end
        end
      end
      mDone = 0;
      if (mBusy) begin
        mRemain--;
        if (mRemain == 0) begin mBusy = 0; mDone = 1; end
      end
      if (go) begin
        mBusy = 1; mRemain = n * (mDiv + 1); mChan = ch; mBits = n - 1;
      end
      mStrobe = go;
      if (!mBurst) mActive = 0;
      else if (go) begin mActive = 1; mLast = ch; end
      for (int k = 0; k < 6; k++) begin pv[k] = s2[k]; s2[k] = s1[k]; s1[k] = trigIn[k]; end
      mSw = wrEn && wrData[26:24] == 3'd1 && !wrData[16];
      if (wrEn) begin
        mMask = int'(wrData[7:0]); mDiv = int'(wrData[15:8]); mBurst = int'(wrData[16]);
        mLen = int'(wrData[19:17]); mStart = int'(wrData[26:24]); mEdge = int'(wrData[27]);
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-clock comparison and observation counters
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      chk(busy == mBusy, "R2 busy", busy, mBusy);
      chk(convStrobe == mStrobe, "R12 convStrobe", convStrobe, mStrobe);
      chk(donePulse == mDone, "R2 donePulse", donePulse, mDone);
      chk(int'(chanIdx) == mChan, "R4 chanIdx", chanIdx, mChan);
      chk(int'(resultBits) == mBits, "R11 resultBits", resultBits, mBits);
      if (convStrobe) strobeCnt++;
      if (busy) busyCnt++;
      if (donePulse) begin doneCnt++; doneChans.push_back(int'(chanIdx)); end
    end
  end

  task automatic clearCounts();
    strobeCnt = 0; doneCnt = 0; busyCnt = 0; doneChans.delete();
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrWord(int edgeB, int start, int len, int burst, int div, int mask);
    @(negedge clk);
    wrData = {4'd0, edgeB[0], start[2:0], 4'd0, len[2:0], burst[0], div[7:0], mask[7:0]};
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    wait_cyc(30000);
    chk(0, "watchdog", cycles, 30000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    chk(busy == 0 && convStrobe == 0 && donePulse == 0 && chanIdx == 0 && resultBits == 0,
        "R1 reset outputs", {busy, convStrobe, donePulse}, 0);
    rstN = 1'b1;
    wait_cyc(10);
    chk(strobeCnt == 0, "R1 idle after reset", strobeCnt, 0);

    // R8 / R3: start-now single conversion, length code ignored
    clearCounts();
    wrWord(0, 1, 5, 0, 1, 8'h14);
    wait_cyc(3);
    wrWord(0, 1, 5, 0, 1, 8'h14);   // R10: second start-now while busy
    wait_cyc(40);
    chk(strobeCnt == 1, "R8 one start-now conversion", strobeCnt, 1);
    chk(busyCnt == 22, "R3 single length 11 clocks div 2", busyCnt, 22);
    chk(doneChans.size() == 1 && doneChans[0] == 2, "R8 lowest mask bit", doneChans.size() ? doneChans[0] : -1, 2);

    // R4 / R11: burst scan with wrap
    clearCounts();
    wrWord(0, 0, 7, 1, 0, 8'h29);
    while (doneCnt < 6) @(negedge clk);
    chk(doneChans[0] == 0 && doneChans[1] == 3 && doneChans[2] == 5, "R4 ascending order", doneChans[1], 3);
    chk(doneChans[3] == 0 && doneChans[4] == 3 && doneChans[5] == 5, "R4 wrap to lowest", doneChans[3], 0);
    // R6: graceful stop
    wrWord(0, 0, 7, 0, 0, 8'h29);
    wait_cyc(20);
    chk(doneCnt == strobeCnt, "R6 running conversion completes", doneCnt, strobeCnt);
    clearCounts();
    wait_cyc(20);
    chk(strobeCnt == 0, "R6 no start after clear", strobeCnt, 0);

    // R5: empty mask in burst
    clearCounts();
    wrWord(0, 0, 6, 1, 0, 8'h00);
    while (doneCnt < 3) @(negedge clk);
    chk(doneChans[0] == 0 && doneChans[1] == 0 && doneChans[2] == 0, "R5 empty mask uses channel 0", doneChans[1], 0);
    wrWord(0, 0, 6, 0, 0, 8'h00);
    wait_cyc(20);

    // R7: burst blocked by nonzero start field
    clearCounts();
    wrWord(0, 3, 2, 1, 0, 8'hff);
    wait_cyc(30);
    chk(strobeCnt == 0, "R7 burst blocked", strobeCnt, 0);
    wrWord(0, 0, 0, 0, 0, 8'h00);
    wait_cyc(5);

    // R9: trigger 2 (start field 4), rising edge
    clearCounts();
    wrWord(0, 4, 3, 0, 0, 8'h40);
    trigIn[1] = 1'b1; wait_cyc(10); trigIn[1] = 1'b0; wait_cyc(10);
    chk(strobeCnt == 0, "R9 other trigger ignored", strobeCnt, 0);
    trigIn[2] = 1'b1; wait_cyc(20);
    chk(strobeCnt == 1 && doneChans.size() == 1 && doneChans[0] == 6, "R9 rising edge starts", strobeCnt, 1);
    trigIn[2] = 1'b0; wait_cyc(20);
    chk(strobeCnt == 1, "R9 falling ignored in rising mode", strobeCnt, 1);

    // R9 falling edge mode, R10 edges while busy
    clearCounts();
    wrWord(1, 4, 3, 0, 0, 8'h40);
    trigIn[2] = 1'b1; wait_cyc(15);
    chk(strobeCnt == 0, "R9 rising ignored in falling mode", strobeCnt, 0);
    trigIn[2] = 1'b0; wait_cyc(5);
    trigIn[2] = 1'b1; wait_cyc(1); trigIn[2] = 1'b0;
    wait_cyc(25);
    chk(strobeCnt == 1, "R10 edge during busy ignored", strobeCnt, 1);
    chk(busyCnt == 11, "R3 trigger conversion 11 clocks", busyCnt, 11);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule